// File: doc/BRIEF.md
# RTC Serial Transaction Master

This block runs complete register transactions on a three-wire serial link to a real-time-clock slave, so software no longer toggles the lines itself. A request carries a 3-bit register address, a read/write flag and 32 bits of write data. The master first holds every line low and polls the slave's ready flag. If ready never comes, it pulses a reset to the slave and tries again. Once the slave is ready, it shifts out the frame: data then address for a write, address only for a read. A direction bit follows. For a read, the master then clocks in 32 bits of reply.

Each bit slot takes two timed phases. In the first, the data and enable lines settle. In the second, the clock is held low. The slot ends by raising the clock, and the slave samples on that rising edge. Every phase, the poll interval, the number of polls per attempt, the reset pulse width and the number of attempts are parameters. Their defaults come from a 200 MHz system clock: 5 µs phases, 10 µs polls and 10 ms per attempt.

Top module: `rtc_serial_master`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` rises on the cycle after acceptance and falls in the cycle where `done` pulses. A request raised while `busy` is high has no effect on the running frame or the slave.
- R2: While idle and while waiting for ready, `ser_clk`, `ser_en` and `ser_din` are all low.
- R3: After acceptance, `ser_ready` is sampled once every `POLL_CYC` cycles. The first sample is taken `POLL_CYC` cycles after acceptance. A high sample starts the frame in the next cycle.
- R4: After `POLL_LIMIT` low samples in one attempt, `ser_reset` is high for `RST_CYC` cycles. Polling then restarts, or, after `TRIES` attempts, the master ends with `done` and `err` high together.
- R5: Every bit slot drives `ser_din` and `ser_en` for `PHASE_CYC` cycles with the clock unchanged. It then drives `ser_clk` low for `PHASE_CYC` cycles and then raises it. `ser_din` and `ser_en` never change in the cycle where `ser_clk` falls.
- R6: A write frame holds `ser_en` high for 35 slots: 32 data bits MSB first, then 3 address bits MSB first. A 36th slot follows with `ser_en` low and `ser_din` = 1, the direction bit.
- R7: A read frame holds `ser_en` high for 3 address slots and then sends a direction slot of 0 with `ser_en` low. It then runs 32 clock slots with `ser_din` low. `ser_dout` is captured `PHASE_CYC` cycles after each of those 32 rising edges and assembled MSB first. The result is presented on `rdata` when `done` pulses.
- R8: Every frame ends with `PHASE_CYC` cycles of `ser_clk` high and the other lines low. After that, all lines go low and `done` pulses for one cycle. `err` is high only together with `done`. `rdata` changes only at the end of a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_addr | input | AW | Slave register address |
| req_wdata | input | DW | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout after all attempts, with done |
| rdata | output | DW | Last successfully read word |
| ser_clk | output | 1 | Serial clock to the slave |
| ser_en | output | 1 | Serial enable to the slave |
| ser_din | output | 1 | Serial data toward the slave |
| ser_dout | input | 1 | Serial data from the slave |
| ser_ready | input | 1 | Slave ready flag |
| ser_reset | output | 1 | Reset pulse to the slave |

## Verification
The bench runs the following transactions against a behavioural slave that decodes frames from the wires:
- Reads and writes with ready already high, which isolate the frame shape and the exact slot timing.
- A read where ready arrives after a few polls, which pins down the poll interval.
- A write where one attempt times out, which exposes the reset pulse and the restart of polling.
- A read where every attempt times out, which separates the error ending from a normal one and shows that `rdata` is held.

The data patterns put a set bit at each end of the word, and one uses all ones, so reversed bit order or a lost bit shows up in the read-back. A request injected in the middle of a frame has to leave both the waveform and the slave's register contents unchanged.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RST,
    ST_BITS,
    ST_CLOSE
  } rsm_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rsm_timer.sv
module rsm_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          term
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign term = (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rsm_retry.sv
module rsm_retry #(
  parameter int unsigned POLL_LIMIT = 1000,
  parameter int unsigned TRIES      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic poll_fail,
  input  logic try_end,
  output logic last_poll,
  output logic last_try
);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam int unsigned TW = $clog2(TRIES + 1);
  localparam logic [PW-1:0] POLL_TOP = PW'(POLL_LIMIT - 1);
  localparam logic [TW-1:0] TRY_TOP  = TW'(TRIES - 1);

  logic [PW-1:0] polls_q, polls_d;
  logic [TW-1:0] tries_q, tries_d;

  assign last_poll = (polls_q == POLL_TOP);
  assign last_try  = (tries_q == TRY_TOP);

  always_comb begin
    polls_d = polls_q;
    if (start || try_end)          polls_d = '0;
    else if (poll_fail && !last_poll) polls_d = polls_q + 1'b1;
    tries_d = tries_q;
    if (start)                     tries_d = '0;
    else if (try_end && !last_try) tries_d = tries_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polls_q <= '0;
      tries_q <= '0;
    end else begin
      polls_q <= polls_d;
      tries_q <= tries_d;
    end
  end

  // R4: an attempt never ends in a cycle that also counts a failed poll
  a_r4_end_not_with_poll: assert property (@(posedge clk) disable iff (!rst_n)
    try_end |-> !poll_fail);
endmodule

// File: rtl/rsm_frame.sv
module rsm_frame #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  input  logic          cap,
  input  logic          sdo,
  output logic          cur_bit,
  output logic          cur_en,
  output logic          nxt_bit,
  output logic          nxt_en,
  output logic          last_slot,
  output logic          rd_sample,
  output logic          is_read,
  output logic [DW-1:0] rx_next
);
  localparam int unsigned NS = DW + AW + 1;
  localparam int unsigned SW = $clog2(NS + 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NS - 1);
  localparam logic [SW-1:0] EN_WR     = SW'(DW + AW);
  localparam logic [SW-1:0] EN_RD     = SW'(AW);
  localparam logic [SW-1:0] RD_FIRST  = SW'(AW + 2);

  logic [NS-1:0] pat_q, pat_d;
  logic [SW-1:0] slot_q, slot_d, en_len;
  logic [DW-1:0] rx_q, rx_d;
  logic          wr_q, wr_d;

  assign en_len    = wr_q ? EN_WR : EN_RD;
  assign cur_bit   = pat_q[NS-1];
  assign nxt_bit   = pat_q[NS-2];
  assign cur_en    = (slot_q < en_len);
  assign nxt_en    = ((slot_q + 1'b1) < en_len);
  assign last_slot = (slot_q == SLOT_LAST);
  assign is_read   = !wr_q;
  assign rd_sample = !wr_q && (slot_q >= RD_FIRST);
  assign rx_next   = {rx_q[DW-2:0], sdo};

  always_comb begin
    pat_d  = pat_q;
    slot_d = slot_q;
    wr_d   = wr_q;
    rx_d   = rx_q;
    if (load) begin
      pat_d  = wr ? {wdata, addr, 1'b1} : {addr, 1'b0, {DW{1'b0}}};
      slot_d = '0;
      wr_d   = wr;
      rx_d   = '0;
    end else begin
      if (adv) begin
        pat_d  = pat_q << 1;
        slot_d = slot_q + 1'b1;
      end
      if (cap) rx_d = rx_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      slot_q <= '0;
      wr_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      pat_q  <= pat_d;
      slot_q <= slot_d;
      wr_q   <= wr_d;
      rx_q   <= rx_d;
    end
  end

  // R6/R7: the slot index never runs past the final slot of a frame
  a_r6_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !last_slot);
endmodule

// File: rtl/rtc_serial_master.sv
module rtc_serial_master
  import rsm_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned PHASE_CYC  = CLK_HZ / 200_000,
  parameter int unsigned POLL_CYC   = CLK_HZ / 100_000,
  parameter int unsigned POLL_LIMIT = 1000,
  parameter int unsigned RST_CYC    = 16,
  parameter int unsigned TRIES      = 3,
  parameter int unsigned AW         = 3,
  parameter int unsigned DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          ser_clk,
  output logic          ser_en,
  output logic          ser_din,
  input  logic          ser_dout,
  input  logic          ser_ready,
  output logic          ser_reset
);
  localparam int unsigned CW = $clog2(max3(PHASE_CYC, POLL_CYC, RST_CYC) + 1);
  localparam logic [CW-1:0] LIM_PHASE = CW'(PHASE_CYC);
  localparam logic [CW-1:0] LIM_POLL  = CW'(POLL_CYC);
  localparam logic [CW-1:0] LIM_RST   = CW'(RST_CYC);

  rsm_state_e    st_q, st_d;
  logic          ph_q, ph_d;
  logic          sclk_q, sclk_d, sen_q, sen_d, sdi_q, sdi_d, srst_q, srst_d;
  logic          done_q, done_d, err_q, err_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [CW-1:0] limit;
  logic          term, tclr;
  logic          accept, poll_fail, try_end, adv, cap;
  logic          last_poll, last_try;
  logic          cur_bit, cur_en, nxt_bit, nxt_en, last_slot, rd_sample, is_read;
  logic [DW-1:0] rx_next;

  assign tclr = (st_q == ST_IDLE) || term;

  rsm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tclr), .limit(limit), .term(term)
  );

  rsm_retry #(.POLL_LIMIT(POLL_LIMIT), .TRIES(TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .start(accept), .poll_fail(poll_fail),
    .try_end(try_end), .last_poll(last_poll), .last_try(last_try)
  );

  rsm_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .wr(req_write), .addr(req_addr),
    .wdata(req_wdata), .adv(adv), .cap(cap), .sdo(ser_dout),
    .cur_bit(cur_bit), .cur_en(cur_en), .nxt_bit(nxt_bit), .nxt_en(nxt_en),
    .last_slot(last_slot), .rd_sample(rd_sample), .is_read(is_read),
    .rx_next(rx_next)
  );

  always_comb begin
    st_d = st_q;  ph_d = ph_q;
    sclk_d = sclk_q;  sen_d = sen_q;  sdi_d = sdi_q;  srst_d = srst_q;
    done_d = 1'b0;  err_d = 1'b0;  rdata_d = rdata_q;
    accept = 1'b0;  poll_fail = 1'b0;  try_end = 1'b0;  adv = 1'b0;  cap = 1'b0;
    limit = LIM_PHASE;
    case (st_q)
      ST_IDLE: begin
        sclk_d = 1'b0;  sen_d = 1'b0;  sdi_d = 1'b0;
        if (req_valid) begin
          accept = 1'b1;
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        limit = LIM_POLL;
        if (term) begin
          if (ser_ready) begin
            st_d = ST_BITS;  ph_d = 1'b0;
            sen_d = cur_en;  sdi_d = cur_bit;
          end else begin
            poll_fail = 1'b1;
            if (last_poll) begin
              st_d = ST_RST;  srst_d = 1'b1;
            end
          end
        end
      end
      ST_RST: begin
        limit = LIM_RST;
        if (term) begin
          srst_d  = 1'b0;
          try_end = 1'b1;
          if (last_try) begin
            st_d = ST_IDLE;  done_d = 1'b1;  err_d = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_BITS: begin
        if (term) begin
          if (!ph_q) begin
            ph_d = 1'b1;  sclk_d = 1'b0;  cap = rd_sample;
          end else begin
            sclk_d = 1'b1;
            if (last_slot) begin
              st_d = ST_CLOSE;  sen_d = 1'b0;  sdi_d = 1'b0;
            end else begin
              adv = 1'b1;  ph_d = 1'b0;
              sen_d = nxt_en;  sdi_d = nxt_bit;
            end
          end
        end
      end
      ST_CLOSE: begin
        if (term) begin
          cap = is_read;
          st_d = ST_IDLE;  sclk_d = 1'b0;  done_d = 1'b1;
          if (is_read) rdata_d = rx_next;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= 1'b0;
      sclk_q <= 1'b0;  sen_q <= 1'b0;  sdi_q <= 1'b0;  srst_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;  rdata_q <= '0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;
      sclk_q <= sclk_d;  sen_q <= sen_d;  sdi_q <= sdi_d;  srst_q <= srst_d;
      done_q <= done_d;  err_q <= err_d;  rdata_q <= rdata_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdata_q;
  assign ser_clk   = sclk_q;
  assign ser_en    = sen_q;
  assign ser_din   = sdi_q;
  assign ser_reset = srst_q;

  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r4_reset_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ser_reset |-> (!ser_en && !ser_clk && busy));
  a_r2_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_en && !ser_din));
  a_r5_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> ($stable(ser_din) && $stable(ser_en)));
endmodule

// File: tb/test_rtc_serial_master.sv
module test_rtc_serial_master;
  localparam int P  = 3;
  localparam int PC = 4;
  localparam int PL = 5;
  localparam int RC = 2;
  localparam int TR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, err, ser_clk, ser_en, ser_din, ser_reset;
  logic [31:0] rdata;
  logic ser_dout = 1'b0;
  logic ser_ready = 1'b0;

  always #2.5 clk = ~clk;

  rtc_serial_master #(.PHASE_CYC(P), .POLL_CYC(PC), .POLL_LIMIT(PL),
                      .RST_CYC(RC), .TRIES(TR)) i_rtc_serial_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_ready(ser_ready),
    .ser_reset(ser_reset)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic exp_busy = 0, exp_done = 0, exp_err = 0, exp_clk = 0, exp_en = 0, exp_din = 0, exp_rst = 0;
  logic [31:0] exp_rdata = '0;
  logic [31:0] exp_mem [8];
  string ctx = "R2";

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    check("R1", "busy", 32'(busy), 32'(exp_busy));
    check("R5", "ser_clk", 32'(ser_clk), 32'(exp_clk));
    check(ctx, "ser_en", 32'(ser_en), 32'(exp_en));
    check(ctx, "ser_din", 32'(ser_din), 32'(exp_din));
    check("R4", "ser_reset", 32'(ser_reset), 32'(exp_rst));
    check("R8", "done", 32'(done), 32'(exp_done));
    check("R4", "err", 32'(err), 32'(exp_err));
    check("R7", "rdata", rdata, exp_rdata);
  end

  // behavioural slave: samples pre-edge line values on each rising serial clock
  logic pclk = 0, pen = 0, pdin = 0;
  logic [63:0] sh = '0;
  int k = 0;
  logic [31:0] word = '0;
  logic [31:0] smem [8];
  always @(negedge clk) begin
    if (ser_en && !pen) begin sh = '0; k = 0; end
    if (ser_clk && !pclk) begin
      if (pen) sh = {sh[62:0], pdin};
      else begin
        k++;
        if (k == 1) begin
          if (pdin) smem[sh[2:0]] = sh[34:3];
          else word = smem[sh[2:0]];
        end else if (k <= 33) ser_dout = word[33-k];
      end
    end
    pclk = ser_clk; pen = ser_en; pdin = ser_din;
  end

  task automatic txn(input bit wr, input logic [2:0] a, input logic [31:0] d,
                     input int nfail, input bit spur);
    logic [35:0] pat;
    int senlen, fails;
    bit got;
    pat = wr ? {d, a, 1'b1} : {a, 1'b0, 32'h0};
    senlen = wr ? 35 : 3;
    fails = 0; got = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    ser_ready = (nfail == 0);
    @(posedge clk);
    exp_busy = 1; ctx = "R3";
    @(negedge clk);
    req_valid = 0;
    if (spur) fork
      begin
        repeat (40) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 3'd6; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 0;
      end
    join_none
    for (int t = 0; t < TR && !got; t++) begin
      for (int p = 0; p < PL && !got; p++) begin
        repeat (PC - 1) @(posedge clk);
        @(negedge clk);
        ser_ready = (fails >= nfail);
        @(posedge clk);
        if (ser_ready) got = 1; else fails++;
      end
      if (!got) begin
        exp_rst = 1; ctx = "R4";
        repeat (RC) @(posedge clk);
        exp_rst = 0; ctx = "R3";
        if (t == TR - 1) begin exp_busy = 0; exp_done = 1; exp_err = 1; ctx = "R2"; end
      end
    end
    if (got) begin
      ctx = wr ? "R6" : "R7";
      exp_en = 1; exp_din = pat[35];
      for (int s = 0; s < 36; s++) begin
        repeat (P) @(posedge clk); exp_clk = 0;
        repeat (P) @(posedge clk); exp_clk = 1;
        if (s < 35) begin exp_din = pat[34-s]; exp_en = (s + 1 < senlen); end
        else begin exp_din = 0; exp_en = 0; end
      end
      repeat (P) @(posedge clk);
      exp_clk = 0; exp_busy = 0; exp_done = 1; ctx = "R2";
      if (wr) exp_mem[a] = d; else exp_rdata = exp_mem[a];
    end
    @(posedge clk);
    exp_done = 0; exp_err = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 8; i++) begin exp_mem[i] = '0; smem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R2", "reset lines", {29'd0, ser_clk, ser_en, ser_din}, 32'd0);
    txn(0, 3'd5, 32'h0, 0, 0);                 // R7 read of empty register
    txn(1, 3'd5, 32'hA5C3_1E70, 0, 0);         // R6 write
    txn(0, 3'd5, 32'h0, 2, 0);                 // R3 late ready, R7 read-back
    @(negedge clk) check("R7", "read-back", rdata, 32'hA5C3_1E70);
    txn(1, 3'd2, 32'h8000_0001, 0, 1);         // R1 request during frame ignored
    txn(0, 3'd6, 32'h0, 0, 0);
    @(negedge clk) check("R1", "ignored request left slave", rdata, 32'h0);
    txn(0, 3'd2, 32'h0, 0, 0);
    @(negedge clk) check("R6", "end bits", rdata, 32'h8000_0001);
    txn(1, 3'd7, 32'hFFFF_FFFF, PL + 1, 0);    // R4 one retry then success
    txn(0, 3'd7, 32'h0, 0, 0);
    @(negedge clk) check("R7", "all ones", rdata, 32'hFFFF_FFFF);
    txn(0, 3'd5, 32'h0, TR * PL, 0);           // R4 every attempt fails
    @(negedge clk) check("R8", "rdata held after error", rdata, 32'hFFFF_FFFF);
    txn(0, 3'd0, 32'h0, 0, 0);                 // R8 recovery after error
    @(negedge clk) check("R8", "read after error", rdata, 32'h0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule